// File: doc/BRIEF.md
# Multicycle Path Hold Checker

This block is a synthesizable run-time monitor for one multicycle timing exception between a launching register and a capturing register in the same clock domain. It watches the launching register's output and a capture strobe from the destination. It also watches a sensitization flag, which is high while the path logic lets the launched value reach the destination. The flag is low when a mux selects another input, or when an OR gate on the path has another input held at 1. When the destination captures while the path is sensitized, the monitor requires that the source made no transition in the last W cycles, counting the capture cycle itself.

W is the path multiplier. When the path crosses an asynchronous boundary, a guard parameter adds one more cycle to W to cover the metastability window. A source that stays stable for a long time but changes shortly before each capture is still a violation, because only the cycles leading up to each capture count. The first violation sets a sticky error flag and records its cycle number. Passing checks and failing checks are tallied in saturating counters, which give coverage figures.

Top module: `mcp_hold_monitor`

## Requirements
- R1: After reset, `err_flag`, `err_cycle`, `pass_count` and `fail_count` are all zero.
- R2: A check fires when `cap_en` and `path_sens` are both high in a warm cycle t. If the source did not change in any of cycles t-W+1..t, where W = `MULT` + `ASYNC_GUARD`, the check passes and `pass_count` goes up by one after that clock edge.
- R3: A fired check fails when the source changed in any of cycles t-W+1..t. A change in cycle k means the value in cycle k differs from the value in cycle k-1. A failed check raises `fail_count` by one and sets `err_flag` after that edge.
- R4: A capture with `path_sens` low, or `path_sens` high without `cap_en`, is ignored: neither counter changes and `err_flag` is not set, even when the source just changed.
- R5: Long stability does not excuse a late change. A source held constant for many cycles, which then changes in the capture cycle or within W-1 cycles before it, fails the check.
- R6: `err_flag` stays set until reset. `err_cycle` holds the cycle number of the first failing check, counted from 0 at the first cycle after reset, and later failures do not overwrite it.
- R7: A change in any single bit of `src_q` counts as a transition.
- R8: Checks are suppressed in cycles 0..W-1 after reset, while the change history fills. The first check that can fire is in cycle W.
- R9: `pass_count` and `fail_count` saturate at 2^`CNT_W`-1 and never wrap.
- R10: With `ASYNC_GUARD` = 1, a change exactly `MULT` cycles before a capture fails. A change `MULT`+1 cycles before it passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the source and destination registers |
| rst | input | 1 | Synchronous active-high reset |
| src_q | input | SRC_W | Output of the launching register |
| cap_en | input | 1 | Destination capture strobe for this cycle |
| path_sens | input | 1 | High while the path logic lets the source reach the destination |
| err_flag | output | 1 | Sticky violation flag |
| err_cycle | output | CYC_W | Cycle number of the first violation |
| pass_count | output | CNT_W | Saturating count of passing checks |
| fail_count | output | CNT_W | Saturating count of failing checks |

## Verification
The hardest situation to reach is the exact edge of the stability window. A change at cycle k followed by a capture at k+W-1 must fail, and a capture at k+W must pass. Off-by-one mistakes sit on both sides of that edge. The bench therefore places changes and captures at exact cycle offsets from a counted reset release. It drives a guarded and an unguarded instance from the same stimulus, so that a single capture separates the two window lengths. Saturation is reached with a narrow counter width, and the warm-up edge is probed by capturing in every cycle right after reset.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

    // Outcome of one capture event at the destination.
    typedef enum logic [1:0] {
        CHK_IDLE = 2'd0,
        CHK_PASS = 2'd1,
        CHK_FAIL = 2'd2
    } chk_kind_e;

    // Raw per-cycle view handed from the history stage to the judge.
    typedef struct packed {
        logic warm;     // enough history gathered since reset
        logic recent;   // a source change lies inside the window
    } hist_view_t;

    // Window length in cycles: multiplier plus the optional guard cycle.
    function automatic int unsigned win_len(input int unsigned mult,
                                            input int unsigned guard);
        return mult + guard;
    endfunction

    // Saturating increment on a 32-bit carrier; callers truncate.
    function automatic logic [31:0] sat_step(input logic [31:0] v,
                                             input logic [31:0] top);
        return (v >= top) ? top : v + 32'd1;
    endfunction

endpackage

// File: rtl/mcp_edge_tap.sv
module mcp_edge_tap #(
    parameter int unsigned SRC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src_q,
    output logic             chg
);
    logic [SRC_W-1:0] src_d;
    logic             prv_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_d   <= '0;
            prv_vld <= 1'b0;
        end else begin
            src_d   <= src_q;
            prv_vld <= 1'b1;
        end
    end

    // Any differing bit is a transition; none before a prior value exists.
    assign chg = prv_vld && (src_q != src_d);

    // R7: a changed input versus the held copy is always reported once history is valid
    a_r7_any_bit: assert property (@(posedge clk) disable iff (rst)
        prv_vld && (src_q != $past(src_q)) |-> chg);

endmodule

// File: rtl/mcp_window.sv
module mcp_window
    import mcp_pkg::*;
#(
    parameter int unsigned WIN = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chg,
    output hist_view_t view
);
    localparam int unsigned HD     = (WIN > 1) ? WIN - 1 : 1;
    localparam int unsigned WARM_W = $clog2(WIN + 1) + 1;
    localparam logic [WARM_W-1:0] WARM_TOP = WARM_W'(WIN);

    logic [WARM_W-1:0] warm_cnt;
    logic              recent;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_cnt <= '0;
        end else if (warm_cnt != WARM_TOP) begin
            warm_cnt <= warm_cnt + 1'b1;
        end
    end

    generate
        if (WIN == 1) begin : g_flat
            assign recent = chg;
        end else begin : g_shift
            logic [HD-1:0] hist;
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist <= '0;
                end else begin
                    hist[0] <= chg;
                    for (int i = 1; i < int'(HD); i++) begin
                        hist[i] <= hist[i-1];
                    end
                end
            end
            // Current cycle plus the WIN-1 preceding cycles.
            assign recent = chg || (|hist);
        end
    endgenerate

    assign view.warm   = (warm_cnt == WARM_TOP);
    assign view.recent = recent;

    // R3: a change one cycle ago is still inside any window of two or more
    a_r3_hist_holds: assert property (@(posedge clk) disable iff (rst)
        (WIN > 1) && $past(chg) && !$past(rst) |-> view.recent);

    // R8: once warm, the monitor stays warm until reset
    a_r8_warm_sticky: assert property (@(posedge clk) disable iff (rst)
        view.warm |=> view.warm);

endmodule

// File: rtl/mcp_judge.sv
module mcp_judge
    import mcp_pkg::*;
(
    input  logic       cap_en,
    input  logic       path_sens,
    input  hist_view_t view,
    output chk_kind_e  kind
);
    logic fire;

    assign fire = cap_en && path_sens && view.warm;

    always_comb begin
        kind = CHK_IDLE;
        if (fire) begin
            kind = view.recent ? CHK_FAIL : CHK_PASS;
        end
    end

endmodule

// File: rtl/mcp_tally.sv
module mcp_tally
    import mcp_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  chk_kind_e        kind,
    output logic             err_flag,
    output logic [CYC_W-1:0] err_cycle,
    output logic [CNT_W-1:0] pass_count,
    output logic [CNT_W-1:0] fail_count
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CYC_W-1:0] CYC_TOP = {CYC_W{1'b1}};

    logic [CYC_W-1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc        <= '0;
            err_flag   <= 1'b0;
            err_cycle  <= '0;
            pass_count <= '0;
            fail_count <= '0;
        end else begin
            if (cyc != CYC_TOP) begin
                cyc <= cyc + 1'b1;
            end
            if (kind == CHK_PASS && pass_count != CNT_TOP) begin
                pass_count <= pass_count + 1'b1;
            end
            if (kind == CHK_FAIL) begin
                if (fail_count != CNT_TOP) begin
                    fail_count <= fail_count + 1'b1;
                end
                if (!err_flag) begin
                    err_flag  <= 1'b1;
                    err_cycle <= cyc;
                end
            end
        end
    end

    // R3: a failing check always leaves the error flag set
    a_r3_fail_sets_err: assert property (@(posedge clk) disable iff (rst)
        kind == CHK_FAIL |=> err_flag);

    // R6: the flag is sticky and the recorded cycle is frozen once set
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag && $stable(err_cycle));

    // R9: counters never wrap from their ceiling
    a_r9_pass_sat: assert property (@(posedge clk) disable iff (rst)
        pass_count == CNT_TOP |=> pass_count == CNT_TOP);
    a_r9_fail_sat: assert property (@(posedge clk) disable iff (rst)
        fail_count == CNT_TOP |=> fail_count == CNT_TOP);

endmodule

// File: rtl/mcp_hold_monitor.sv
module mcp_hold_monitor
    import mcp_pkg::*;
#(
    parameter int unsigned SRC_W       = 8,
    parameter int unsigned MULT        = 3,
    parameter int unsigned ASYNC_GUARD = 0,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned CYC_W       = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src_q,
    input  logic             cap_en,
    input  logic             path_sens,
    output logic             err_flag,
    output logic [CYC_W-1:0] err_cycle,
    output logic [CNT_W-1:0] pass_count,
    output logic [CNT_W-1:0] fail_count
);
    localparam int unsigned WIN = win_len(MULT, (ASYNC_GUARD != 0) ? 1 : 0);

    logic       chg;
    hist_view_t view;
    chk_kind_e  kind;

    mcp_edge_tap #(.SRC_W(SRC_W)) u_tap (
        .clk   (clk),
        .rst   (rst),
        .src_q (src_q),
        .chg   (chg)
    );

    mcp_window #(.WIN(WIN)) u_win (
        .clk  (clk),
        .rst  (rst),
        .chg  (chg),
        .view (view)
    );

    mcp_judge u_judge (
        .cap_en    (cap_en),
        .path_sens (path_sens),
        .view      (view),
        .kind      (kind)
    );

    mcp_tally #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_tally (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .err_flag   (err_flag),
        .err_cycle  (err_cycle),
        .pass_count (pass_count),
        .fail_count (fail_count)
    );

    // R4: with no sensitized capture the tallies do not move
    a_r4_idle_no_count: assert property (@(posedge clk) disable iff (rst)
        !(cap_en && path_sens) |=> $stable(pass_count) && $stable(fail_count));

    // R2: a sensitized capture with a quiet source never sets a fresh error
    a_r2_quiet_no_err: assert property (@(posedge clk) disable iff (rst)
        !err_flag && !view.recent |=> !err_flag);

    // R8: nothing is judged before the history has filled
    a_r8_cold_idle: assert property (@(posedge clk) disable iff (rst)
        !view.warm |-> kind == CHK_IDLE);

endmodule

// File: tb/mcp_hold_monitor_tb_top.sv
module mcp_hold_monitor_tb_top;
    localparam int SRC_W = 8;
    localparam int MULT  = 3;
    localparam int CNT_W = 3;
    localparam int CYC_W = 16;
    localparam int SAT   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [SRC_W-1:0] src_q = '0;
    logic             cap_en = 1'b0;
    logic             path_sens = 1'b0;

    logic             e_s, e_a;
    logic [CYC_W-1:0] ec_s, ec_a;
    logic [CNT_W-1:0] pc_s, pc_a, fc_s, fc_a;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int wd     = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc = 0;
        else     cyc = cyc + 1;
        wd = wd + 1;
        if (wd > 200000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", wd, 200000);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    mcp_hold_monitor #(.SRC_W(SRC_W), .MULT(MULT), .ASYNC_GUARD(0),
                       .CNT_W(CNT_W), .CYC_W(CYC_W)) dut_i (
        .clk(clk), .rst(rst), .src_q(src_q), .cap_en(cap_en), .path_sens(path_sens),
        .err_flag(e_s), .err_cycle(ec_s), .pass_count(pc_s), .fail_count(fc_s));

    mcp_hold_monitor #(.SRC_W(SRC_W), .MULT(MULT), .ASYNC_GUARD(1),
                       .CNT_W(CNT_W), .CYC_W(CYC_W)) dut_async_i (
        .clk(clk), .rst(rst), .src_q(src_q), .cap_en(cap_en), .path_sens(path_sens),
        .err_flag(e_a), .err_cycle(ec_a), .pass_count(pc_a), .fail_count(fc_a));

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, return at the next falling edge.
    task automatic step(input logic [SRC_W-1:0] s, input logic c, input logic p);
        src_q = s; cap_en = c; path_sens = p;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cap_en = 1'b0; path_sens = 1'b0; src_q = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n, input logic [SRC_W-1:0] s);
        for (int i = 0; i < n; i++) step(s, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 err_flag", e_s, 0);
        chk("R1 err_cycle", ec_s, 0);
        chk("R1 pass_count", pc_s, 0);
        chk("R1 fail_count", fc_a, 0);
    endtask

    task automatic t_pass();
        do_reset();
        idle(6, 8'h11);
        step(8'h11, 1'b1, 1'b1);
        chk("R2 pass sync", pc_s, 1);
        chk("R2 pass async", pc_a, 1);
        chk("R2 no err", e_s, 0);
    endtask

    task automatic t_window_edges();
        // change at k, capture at k+2: inside the 3-cycle window
        do_reset();
        idle(6, 8'h00);
        step(8'h5A, 1'b0, 1'b1);
        step(8'h5A, 1'b0, 1'b1);
        step(8'h5A, 1'b1, 1'b1);
        chk("R3 fail count", fc_s, 1);
        chk("R3 err set", e_s, 1);
        chk("R3 no pass", pc_s, 0);
        // change at k, capture at k+3: unguarded passes, guarded fails
        do_reset();
        idle(6, 8'h00);
        step(8'h5A, 1'b0, 1'b1);
        idle(2, 8'h5A);
        step(8'h5A, 1'b1, 1'b1);
        chk("R2 edge pass", pc_s, 1);
        chk("R10 guard fail", fc_a, 1);
        // change at k, capture at k+4: guarded passes
        do_reset();
        idle(6, 8'h00);
        step(8'h5A, 1'b0, 1'b1);
        idle(3, 8'h5A);
        step(8'h5A, 1'b1, 1'b1);
        chk("R10 guard pass", pc_a, 1);
        chk("R10 guard no err", e_a, 0);
    endtask

    task automatic t_masked();
        do_reset();
        idle(6, 8'h00);
        step(8'hFF, 1'b1, 1'b0);
        step(8'h0F, 1'b0, 1'b1);
        step(8'hF0, 1'b1, 1'b0);
        chk("R4 masked pass", pc_s, 0);
        chk("R4 masked fail", fc_s, 0);
        chk("R4 masked err", e_a, 0);
    endtask

    task automatic t_long_then_late();
        int k;
        do_reset();
        idle(20, 8'h33);
        k = cyc;
        step(8'h34, 1'b1, 1'b1);
        chk("R5 late change fails", fc_s, 1);
        chk("R6 first cycle", ec_s, k);
        idle(10, 8'h34);
        step(8'h35, 1'b1, 1'b1);
        chk("R6 second fail counted", fc_s, 2);
        chk("R6 cycle kept", ec_s, k);
        idle(4, 8'h35);
        chk("R6 sticky", e_s, 1);
    endtask

    task automatic t_single_bit();
        do_reset();
        idle(6, 8'h00);
        step(8'h80, 1'b0, 1'b1);
        step(8'h80, 1'b1, 1'b1);
        chk("R7 msb flip", fc_s, 1);
        do_reset();
        idle(6, 8'h00);
        step(8'h01, 1'b1, 1'b1);
        chk("R7 lsb flip", fc_a, 1);
    endtask

    task automatic t_warm();
        do_reset();
        step(8'h00, 1'b1, 1'b1);
        step(8'h00, 1'b1, 1'b1);
        step(8'h00, 1'b1, 1'b1);
        chk("R8 cold sync", pc_s + fc_s, 0);
        step(8'h00, 1'b1, 1'b1);
        chk("R8 first warm sync", pc_s, 1);
        chk("R8 async still cold", pc_a + fc_a, 0);
        step(8'h00, 1'b1, 1'b1);
        chk("R8 first warm async", pc_a, 1);
    endtask

    task automatic t_saturate();
        do_reset();
        idle(6, 8'h00);
        for (int i = 0; i < 10; i++) step(8'h00, 1'b1, 1'b1);
        chk("R9 pass saturates", pc_s, SAT);
        for (int i = 0; i < 10; i++) step(8'(i + 1), 1'b1, 1'b1);
        chk("R9 fail saturates", fc_s, SAT);
        chk("R9 pass held", pc_s, SAT);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_window_edges();
        t_masked();
        t_long_then_late();
        t_single_bit();
        t_warm();
        t_saturate();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule